// File: doc/BRIEF.md
# Stereo Audio Serial Timing Generator

This block drives the serial bus of a stereo audio DAC from one system clock. Two divider settings arrive as inputs. A 14-bit frame-period value fixes the sample rate: one frame lasts `period_i + 1` clock cycles. A 4-bit half-period value fixes the bit clock: each phase of the bit clock lasts `half_i + 1` cycles. In every frame the block shifts out a held 32-bit stereo word. The word goes out MSB first, the left channel in the upper 16 bits and the right channel in the lower 16. The bit clock and a word-select line come out with it.

Samples come from an upstream source through a valid/ready pair. A new word is taken only in the cycle that opens a frame. If no word is offered at that point, the held word is sent again. The frame down-counter and the bit-clock level are visible on ports for status reads. When the half-period value is zero, the block acts as a soft reset: it goes quiet and discards the held word. Software must keep `period_i + 1 >= 66 * (half_i + 1)`. That leaves room for 32 bit periods and a short quiet gap in every frame.

The bit sequencer has three states:
- IDLE: held while the block is disabled.
- SHIFT: the 32 bits are being sent.
- GAP: the bus is quiet until the frame ends.

It has these transitions:
- IDLE→SHIFT when a frame opens.
- SHIFT→GAP on the falling edge that ends bit 31.
- GAP→SHIFT when the next frame opens.
- SHIFT→SHIFT when a frame opens early.
- SHIFT→IDLE and GAP→IDLE when a divider becomes zero.

Top module: `audio_serial_tx`

## Requirements
- R1: After reset, with both dividers zero: `bclk_o`=0, `wsel_o`=1, `sdata_o`=0, `cntr_o`=0 and `smp_ready_o`=0.
- R2: With both dividers nonzero, `cntr_o` is loaded with `period_i` when a frame opens and falls by one each cycle. `smp_ready_o` is high exactly in the cycle where `cntr_o`=0, so it pulses once every `period_i+1` cycles.
- R3: From the cycle after a frame opens, `bclk_o` is low for `half_i+1` cycles and then high for `half_i+1` cycles. This repeats for 32 periods, after which `bclk_o` stays low until the next frame.
- R4: During bit period k (k=0..31), `sdata_o` equals bit 31-k of the frame's word. It therefore changes only at a falling edge of the bit clock or at the start of a frame. `sdata_o` is 0 outside the 32 bit periods.
- R5: `wsel_o` is 1 (left) during bit periods 0..15 and during the gap. It is 0 (right) during bit periods 16..31.
- R6: A word is captured only in a cycle with `smp_ready_o` and `smp_valid_i` both high, and it is sent in the frame that opens at that edge. A valid word offered in the middle of a frame does not change that frame.
- R7: When `smp_valid_i` is low as a frame opens, the previously held word is sent again.
- R8: While `half_i`=0: `bclk_o`=0, `sdata_o`=0, `wsel_o`=1, `cntr_o`=0 and `smp_ready_o`=0. The held word is cleared to zero, so a later frame with no new word sends zeros.
- R9: While `period_i`=0 and `half_i`≠0, the outputs are quiet as in R8, but the held word is kept and is sent again once `period_i` becomes nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_i | input | 14 | Frame period minus one |
| half_i | input | 4 | Bit-clock half period minus one; zero is a soft reset |
| smp_data_i | input | 32 | Stereo word, left channel in [31:16] |
| smp_valid_i | input | 1 | Upstream word valid |
| smp_ready_o | output | 1 | Frame opens this cycle; the word is taken if valid |
| bclk_o | output | 1 | Serial bit clock |
| wsel_o | output | 1 | Word select, 1 = left |
| sdata_o | output | 1 | Serial data, MSB first |
| cntr_o | output | 14 | Frame down-counter value |

## Verification
A wrong frame counter shows up on `cntr_o` in the very next cycle. It also shifts the `smp_ready_o` pulse by whole frames. A bit sequencer that is in the wrong state, or whose half-period or bit-index counter has slipped, changes `bclk_o`, `sdata_o` or `wsel_o` within one half period of the error. A capture or hold fault in the stored word shows in the first bit of the following frame. The bench therefore compares every output in every cycle of each frame it captures against values derived from the divider settings.

// File: rtl/audio_serial_pkg.sv
package audio_serial_pkg;
    localparam int SAMPLE_W = 32;
    localparam int PERIOD_W = 14;
    localparam int HALF_W   = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_GAP   = 2'd2
    } bit_state_t;
endpackage

// File: rtl/audio_frame_counter.sv
module audio_frame_counter #(
    parameter int PERIOD_W = 14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                active,
    input  logic [PERIOD_W-1:0] period,
    output logic [PERIOD_W-1:0] cntr,
    output logic                boundary
);
    logic [PERIOD_W-1:0] cntr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cntr_q <= '0;
        end else if (!active) begin
            cntr_q <= '0;
        end else if (cntr_q == '0) begin
            cntr_q <= period;
        end else begin
            cntr_q <= cntr_q - 1'b1;
        end
    end

    assign cntr     = cntr_q;
    assign boundary = active && (cntr_q == '0);

    // R2: the counter steps down by one inside a frame
    assert_count_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (active && cntr_q != '0) |=> (!active || cntr_q == $past(cntr_q) - 1'b1));

    // R8: a disabled block holds the counter at zero
    assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (cntr_q == '0 || active));
endmodule

// File: rtl/audio_bit_fsm.sv
module audio_bit_fsm
    import audio_serial_pkg::*;
#(
    parameter int SMP_W = 32,
    parameter int HW    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             boundary,
    input  logic [HW-1:0]    half,
    input  logic [SMP_W-1:0] load_word,
    output logic             bclk_o,
    output logic             sdata_o,
    output logic             wsel_o
);
    localparam int IDX_W = $clog2(SMP_W);
    localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(SMP_W - 1);
    localparam logic [IDX_W-1:0] RIGHT_IDX = IDX_W'(SMP_W / 2);

    bit_state_t       state_q, state_d;
    logic [HW-1:0]    hcnt_q;
    logic [IDX_W-1:0] bitidx_q;
    logic [SMP_W-1:0] shreg_q;
    logic             bclk_q;
    logic             last_fall;

    assign last_fall = (state_q == ST_SHIFT) && (hcnt_q == '0) && bclk_q
                       && (bitidx_q == LAST_IDX);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (boundary) state_d = ST_SHIFT;
            ST_SHIFT: begin
                if (!active)        state_d = ST_IDLE;
                else if (boundary)  state_d = ST_SHIFT;
                else if (last_fall) state_d = ST_GAP;
            end
            ST_GAP: begin
                if (!active)        state_d = ST_IDLE;
                else if (boundary)  state_d = ST_SHIFT;
            end
            default:                state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // bit timing datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bclk_q   <= 1'b0;
            hcnt_q   <= '0;
            bitidx_q <= '0;
            shreg_q  <= '0;
        end else if (!active) begin
            bclk_q   <= 1'b0;
            hcnt_q   <= '0;
            bitidx_q <= '0;
            shreg_q  <= '0;
        end else if (boundary) begin
            bclk_q   <= 1'b0;
            hcnt_q   <= half;
            bitidx_q <= '0;
            shreg_q  <= load_word;
        end else if (state_q == ST_SHIFT) begin
            if (hcnt_q == '0) begin
                hcnt_q <= half;
                bclk_q <= ~bclk_q;
                if (bclk_q && bitidx_q != LAST_IDX) begin
                    bitidx_q <= bitidx_q + 1'b1;
                    shreg_q  <= {shreg_q[SMP_W-2:0], 1'b0};
                end
            end else begin
                hcnt_q <= hcnt_q - 1'b1;
            end
        end else begin
            bclk_q <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        bclk_o  = bclk_q;
        sdata_o = (state_q == ST_SHIFT) ? shreg_q[SMP_W-1] : 1'b0;
        wsel_o  = !((state_q == ST_SHIFT) && (bitidx_q >= RIGHT_IDX));
    end

    // R3: bit clock is low outside the shifting state
    assert_bclk_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_SHIFT) |-> !bclk_q);

    // R3: bit clock rises only after a full half period in SHIFT
    assert_bclk_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bclk_q) |-> ($past(hcnt_q) == '0 && $past(state_q) == ST_SHIFT));

    // R4: data holds steady except at a falling edge or frame start
    assert_data_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT && $past(state_q) == ST_SHIFT
         && !$fell(bclk_q) && !$past(boundary)) |-> $stable(sdata_o));
endmodule

// File: rtl/audio_serial_tx.sv
module audio_serial_tx
    import audio_serial_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PERIOD_W-1:0] period_i,
    input  logic [HALF_W-1:0]   half_i,
    input  logic [SAMPLE_W-1:0] smp_data_i,
    input  logic                smp_valid_i,
    output logic                smp_ready_o,
    output logic                bclk_o,
    output logic                wsel_o,
    output logic                sdata_o,
    output logic [PERIOD_W-1:0] cntr_o
);
    logic                active;
    logic                boundary;
    logic                soft_rst;
    logic [SAMPLE_W-1:0] held_q;
    logic [SAMPLE_W-1:0] next_word;

    assign soft_rst  = (half_i == '0);
    assign active    = !soft_rst && (period_i != '0);
    assign next_word = smp_valid_i ? smp_data_i : held_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        held_q <= '0;
        else if (soft_rst)                 held_q <= '0;
        else if (boundary && smp_valid_i)  held_q <= smp_data_i;
    end

    audio_frame_counter #(.PERIOD_W(PERIOD_W)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .period   (period_i),
        .cntr     (cntr_o),
        .boundary (boundary)
    );

    audio_bit_fsm #(.SMP_W(SAMPLE_W), .HW(HALF_W)) u_bits (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .boundary  (boundary),
        .half      (half_i),
        .load_word (next_word),
        .bclk_o    (bclk_o),
        .sdata_o   (sdata_o),
        .wsel_o    (wsel_o)
    );

    assign smp_ready_o = boundary;

    // R6: an accepted word becomes the held word
    assert_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_ready_o && smp_valid_i && !soft_rst) |=> held_q == $past(smp_data_i));

    // R7: without a handshake the held word is kept
    assert_hold_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_ready_o && !soft_rst) |=> $stable(held_q));

    // R8: soft reset clears the held word
    assert_soft_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> held_q == '0);
endmodule

// File: tb/audio_serial_tx_bench.sv
module audio_serial_tx_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] period_i = '0;
    logic [3:0]  half_i = '0;
    logic [31:0] smp_data_i = '0;
    logic        smp_valid_i = 1'b0;
    logic        smp_ready_o, bclk_o, wsel_o, sdata_o;
    logic [13:0] cntr_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    audio_serial_tx u_audio_serial_tx (
        .clk(clk), .rst_n(rst_n), .period_i(period_i), .half_i(half_i),
        .smp_data_i(smp_data_i), .smp_valid_i(smp_valid_i),
        .smp_ready_o(smp_ready_o), .bclk_o(bclk_o), .wsel_o(wsel_o),
        .sdata_o(sdata_o), .cntr_o(cntr_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_quiet(input string req);
        check(bclk_o == 1'b0, req, "bclk quiet", int'(bclk_o), 0);
        check(sdata_o == 1'b0, req, "sdata quiet", int'(sdata_o), 0);
        check(wsel_o == 1'b1, req, "wsel left", int'(wsel_o), 1);
        check(cntr_o == '0, req, "cntr zero", int'(cntr_o), 0);
        check(smp_ready_o == 1'b0, req, "ready low", int'(smp_ready_o), 0);
    endtask

    task automatic wait_ready();
        while (!smp_ready_o) @(negedge clk);
    endtask

    // Capture one whole frame; optionally offer word injv at cycle inj.
    task automatic run_frame(input int h, input int p, input logic [31:0] exp,
                             input int inj, input logic [31:0] injv);
        int e_clk = 0, e_dat = 0, e_ws = 0, e_cnt = 0, e_rdy = 0;
        int a_dat = 0, x_dat = 0;
        int bitlen = 2 * (h + 1);
        wait_ready();
        @(posedge clk);
        @(negedge clk);
        smp_valid_i = 1'b0;
        for (int t = 0; t <= p; t++) begin
            int k = t / bitlen;
            logic xb, xd, xw;
            if (t == inj) begin
                smp_data_i  = injv;
                smp_valid_i = 1'b1;
            end
            xb = (t < 32 * bitlen) ? logic'((t / (h + 1)) % 2) : 1'b0;
            xd = (t < 32 * bitlen) ? exp[31 - k] : 1'b0;
            xw = (t < 32 * bitlen) ? (k < 16) : 1'b1;
            if (bclk_o !== xb) e_clk++;
            if (sdata_o !== xd) begin
                if (e_dat == 0) begin a_dat = int'(sdata_o); x_dat = t; end
                e_dat++;
            end
            if (wsel_o !== xw) e_ws++;
            if (cntr_o !== 14'(p - t)) e_cnt++;
            if (smp_ready_o !== (t == p)) e_rdy++;
            if (t < p) @(negedge clk);
        end
        check(e_cnt == 0, "R2", "cntr mismatches", e_cnt, 0);
        check(e_rdy == 0, "R2", "ready pulse mismatches", e_rdy, 0);
        check(e_clk == 0, "R3", "bclk mismatches", e_clk, 0);
        check(e_dat == 0, "R4", "sdata mismatches (first bit value/cycle)", a_dat, x_dat);
        check(e_ws == 0, "R5", "wsel mismatches", e_ws, 0);
    endtask

    task automatic soft_reset();
        @(negedge clk);
        half_i = '0;
        repeat (3) @(negedge clk);
        check_quiet("R8");
    endtask

    initial begin
        int hs[4] = '{1, 2, 3, 5};
        int ps[4] = '{131, 199, 271, 400};
        repeat (3) @(negedge clk);
        check_quiet("R1");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_quiet("R1");

        for (int c = 0; c < 4; c++) begin
            logic [31:0] w1 = 32'hA5C3_0F01 ^ (32'h1357_9BDF * (c + 1));
            logic [31:0] w2 = ~w1 ^ 32'h8000_0001;
            period_i    = 14'(ps[c]);
            half_i      = 4'(hs[c]);
            smp_data_i  = w1;
            smp_valid_i = 1'b1;
            // R6: word captured at frame start; w2 offered mid-frame
            run_frame(hs[c], ps[c], w1, 40, w2);
            // R6: mid-frame offer lands in the following frame
            run_frame(hs[c], ps[c], w2, -1, '0);
            // R7: no valid at frame start, held word repeats
            run_frame(hs[c], ps[c], w2, -1, '0);
            soft_reset();
        end

        // R8: held word cleared by soft reset, zeros sent after re-enable
        period_i = 14'd140;
        half_i   = 4'd1;
        run_frame(1, 140, 32'h0, -1, '0);

        // R9: zero period idles but keeps the held word
        smp_data_i  = 32'hFFFF_0001;
        smp_valid_i = 1'b1;
        run_frame(1, 140, 32'hFFFF_0001, -1, '0);
        @(negedge clk);
        period_i = '0;
        repeat (3) @(negedge clk);
        check_quiet("R9");
        period_i = 14'd140;
        run_frame(1, 140, 32'hFFFF_0001, -1, '0);

        done = 1;
    end

    initial begin
        for (int n = 0; n < 150000 && !done; n++) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule